// File: doc/BRIEF.md
# Time-Multiplexed Phase Accumulator Oscillator Bank

The block is a bank of digital oscillators. All channels share one adder, one frequency-word store, one accumulator store and one waveform table, and the channels take turns in a fixed rotation. Each channel gets one minor cycle of eight clocks. The first four clocks form the internal half. In that half the serviced channel's frequency word is added to its accumulator, and the sum is written back. The accumulator value from before the add is used to look up an 8-bit sample in the waveform table. That sample is latched into a DAC output register.

The last four clocks form the external half. In that half a host may write one frequency word or one waveform sample through a valid/ready port. A request made at any other time waits until the next external half.

Because of the pipeline, each sample is delivered one minor cycle late. For this reason every sample comes out with a channel tag that names the oscillator it belongs to.

Top module: `osc_bank_top`

## Requirements
- R1: Channels are serviced in ascending order, one per minor cycle of 8 clocks, wrapping from the last channel to 0. The first minor cycle after reset services channel 0, and `dac_chan` reports that order.
- R2: Each time a channel is serviced, its 16-bit accumulator grows by its frequency word, modulo 2^16. There is no carry out.
- R3: `host_ready` is high only in clock 4 of a minor cycle, which is the first clock of the external half (clocks counted 0..7). A write takes effect when `host_valid` and `host_ready` are both high at a rising edge.
- R4: The sum is held from clock 2 and committed at the end of clock 3. A frequency word written in an external half is first used at that channel's next service.
- R5: The sample is read from table address {channel index (upper 4 bits), bits 15:10 of the accumulator before the add (lower 6 bits)}. It is latched at the end of clock 3 and then held for a full minor cycle.
- R6: `dac_chan` equals the channel whose sample is on `dac_sample`. During clocks 0..3 of minor cycle N, both show channel N-1.
- R7: Reset clears the accumulators, the frequency words, the channel counter, the clock phase, `dac_sample` and `dac_chan`. While reset is high, `host_ready` is low.
- R8: `host_tgt`=0 writes `host_data[15:0]` as the frequency word of the channel given by `host_addr[3:0]`, and ignores the upper address bits. `host_tgt`=1 writes `host_data[7:0]` into the waveform table at `host_addr[9:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_valid | input | 1 | Host write request |
| host_ready | output | 1 | High in the one clock that accepts a host write |
| host_tgt | input | 1 | Write target: 0 = frequency word, 1 = waveform sample |
| host_addr | input | 10 | Channel (low 4 bits) or waveform table address |
| host_data | input | 16 | Write data |
| dac_sample | output | 8 | Latched waveform sample |
| dac_chan | output | 4 | Channel that the current sample belongs to |

## Verification
The bank is run in five settings.

- **All frequency words zero.** This shows whether reset really cleared the accumulators.
- **Frequency words that are whole multiples of one table step.** The channels then walk the table at different speeds, and each wraps at its own rate.
- **Words with low-order bits set.** This exposes carries from the fractional part into the address bits.
- **Words rewritten mid-run,** including a nearly full-scale word that makes the phase step backwards. This separates a design that applies a new word at the right service from one that applies it a cycle early or late.
- **Waveform samples overwritten, and frequency writes with high address bits set.** This tests how the table index is formed and how the target select is decoded.

// File: rtl/osc_pkg.sv
package osc_pkg;

    typedef logic [2:0] phase_t;

    // Clock slots within one minor cycle (0..3 internal, 4..7 external)
    localparam phase_t PH_CAPTURE = 3'd1;  // sum captured at the edge ending this clock
    localparam phase_t PH_COMMIT  = 3'd3;  // write-back and DAC latch at the edge ending this clock
    localparam phase_t PH_HOST    = 3'd4;  // host slot
    localparam phase_t PH_LAST    = 3'd7;

    typedef enum logic {
        TGT_FREQ = 1'b0,
        TGT_WAVE = 1'b1
    } host_tgt_e;

endpackage

// File: rtl/osc_sequencer.sv
module osc_sequencer
    import osc_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    output phase_t          phase,
    output logic [CH_W-1:0] chan
);

    typedef struct packed {
        phase_t          phase;
        logic [CH_W-1:0] chan;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = st_q.phase + 1'b1;
        if (st_q.phase == PH_LAST) begin
            st_d.chan = st_q.chan + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign chan  = st_q.chan;

    AST_CHAN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LAST) |=> (chan == $past(chan) + 1'b1)); // R1
    AST_CHAN_STEADY: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_LAST) |=> $stable(chan)); // R1

endmodule

// File: rtl/osc_acc_bank.sv
module osc_acc_bank
    import osc_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int CH_W  = 4,
    parameter int ACC_W = 16,
    parameter int TOP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_t           phase,
    input  logic [CH_W-1:0]  chan,
    input  logic             fwr_en,
    input  logic [CH_W-1:0]  fwr_ch,
    input  logic [ACC_W-1:0] fwr_data,
    output logic [TOP_W-1:0] old_top
);

    typedef struct packed {
        logic [NCH-1:0][ACC_W-1:0] acc;
        logic [NCH-1:0][ACC_W-1:0] freq;
        logic [ACC_W-1:0]          hold;
        logic [TOP_W-1:0]          old_top;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (phase == PH_CAPTURE) begin
            st_d.hold    = st_q.acc[chan] + st_q.freq[chan];
            st_d.old_top = st_q.acc[chan][ACC_W-1 -: TOP_W];
        end
        if (phase == PH_COMMIT) begin
            st_d.acc[chan] = st_q.hold;
        end
        if (fwr_en) begin
            st_d.freq[fwr_ch] = fwr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign old_top = st_q.old_top;

    AST_HOLD_ONLY_AT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_CAPTURE) |=> $stable(st_q.hold)); // R4
    AST_ACC_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_COMMIT) |=> $stable(st_q.acc)); // R2

endmodule

// File: rtl/osc_wave_table.sv
module osc_wave_table
    import osc_pkg::*;
#(
    parameter int CH_W  = 4,
    parameter int TOP_W = 6,
    parameter int SMP_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  phase_t                phase,
    input  logic [CH_W-1:0]       chan,
    input  logic [TOP_W-1:0]      old_top,
    input  logic                  wwr_en,
    input  logic [CH_W+TOP_W-1:0] wwr_addr,
    input  logic [SMP_W-1:0]      wwr_data,
    output logic [SMP_W-1:0]      dac,
    output logic [CH_W-1:0]       tag
);

    localparam int ADDR_W = CH_W + TOP_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [SMP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wwr_en) begin
            mem[wwr_addr] <= wwr_data;
        end
    end

    typedef struct packed {
        logic [SMP_W-1:0] dac;
        logic [CH_W-1:0]  tag;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (phase == PH_COMMIT) begin
            st_d.dac = mem[{chan, old_top}];
            st_d.tag = chan;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac = st_q.dac;
    assign tag = st_q.tag;

    AST_DAC_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_COMMIT) |=> ($stable(dac) && $stable(tag))); // R5

endmodule

// File: rtl/osc_bank_top.sv
module osc_bank_top
    import osc_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int ACC_W = 16,
    parameter int TOP_W = 6,
    parameter int SMP_W = 8,
    localparam int CH_W    = $clog2(NCH),
    localparam int WADDR_W = CH_W + TOP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_valid,
    output logic               host_ready,
    input  logic               host_tgt,
    input  logic [WADDR_W-1:0] host_addr,
    input  logic [ACC_W-1:0]   host_data,
    output logic [SMP_W-1:0]   dac_sample,
    output logic [CH_W-1:0]    dac_chan
);

    phase_t           phase;
    logic [CH_W-1:0]  chan;
    logic [TOP_W-1:0] old_top;
    logic             accept;
    logic             fwr_en;
    logic             wwr_en;

    osc_sequencer #(.CH_W(CH_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .chan  (chan)
    );

    always_comb begin
        host_ready = (phase == PH_HOST);
        accept     = host_valid && host_ready;
        fwr_en     = accept && (host_tgt == TGT_FREQ);
        wwr_en     = accept && (host_tgt == TGT_WAVE);
    end

    osc_acc_bank #(
        .NCH   (NCH),
        .CH_W  (CH_W),
        .ACC_W (ACC_W),
        .TOP_W (TOP_W)
    ) u_acc (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .chan     (chan),
        .fwr_en   (fwr_en),
        .fwr_ch   (host_addr[CH_W-1:0]),
        .fwr_data (host_data),
        .old_top  (old_top)
    );

    osc_wave_table #(
        .CH_W  (CH_W),
        .TOP_W (TOP_W),
        .SMP_W (SMP_W)
    ) u_wave (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .chan     (chan),
        .old_top  (old_top),
        .wwr_en   (wwr_en),
        .wwr_addr (host_addr),
        .wwr_data (host_data[SMP_W-1:0]),
        .dac      (dac_sample),
        .tag      (dac_chan)
    );

    AST_READY_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        host_ready |=> !host_ready); // R3
    AST_TAG_SKEW: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOST) |-> (dac_chan == chan)); // R6

endmodule

// File: tb/tb_osc_bank_top.sv
module tb_osc_bank_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 16;
    localparam int ACC_W = 16;
    localparam int TOP_W = 6;
    localparam int SMP_W = 8;
    localparam int CH_W  = 4;
    localparam int WA_W  = CH_W + TOP_W;
    localparam int WDEP  = 1 << WA_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             host_valid = 1'b0;
    logic             host_ready;
    logic             host_tgt = 1'b0;
    logic [WA_W-1:0]  host_addr = '0;
    logic [ACC_W-1:0] host_data = '0;
    logic [SMP_W-1:0] dac_sample;
    logic [CH_W-1:0]  dac_chan;

    osc_bank_top dut (
        .clk        (clk),
        .rst        (rst),
        .host_valid (host_valid),
        .host_ready (host_ready),
        .host_tgt   (host_tgt),
        .host_addr  (host_addr),
        .host_data  (host_data),
        .dac_sample (dac_sample),
        .dac_chan   (dac_chan)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int unsigned ecount = 0;
    always @(posedge clk) if (!rst) ecount <= ecount + 1;

    int  nchk  = 0;
    int  nfail = 0;
    bit  done  = 0;
    bit  chk_en = 0;
    string scen = "R7";

    logic [ACC_W-1:0] m_acc  [NCH];
    logic [ACC_W-1:0] m_freq [NCH];
    logic [SMP_W-1:0] m_wave [WDEP];

    typedef struct {
        logic [SMP_W-1:0] smp;
        logic [CH_W-1:0]  ch;
        bit               chk;
        string            tag;
    } exp_t;
    exp_t sb[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [SMP_W-1:0] wave_fn(input int a);
        return SMP_W'((a * 37 + 5) ^ (a >> 3));
    endfunction

    // Predictor: runs in clock 1 of every minor cycle, pushes expected sample
    always @(negedge clk) begin
        if (!rst && (ecount % 8 == 1)) begin
            automatic int unsigned k = ecount / 8;
            automatic logic [CH_W-1:0] c = CH_W'(k % NCH);
            automatic exp_t e;
            e.smp = m_wave[{c, m_acc[c][ACC_W-1 -: TOP_W]}];
            e.ch  = c;
            e.chk = chk_en;
            e.tag = scen;
            sb.push_back(e);
            m_acc[c] = m_acc[c] + m_freq[c];
            if (chk_en && k > 0)
                check(dac_chan == CH_W'((k - 1) % NCH), "R6 skewed tag in clocks 0..3",
                      int'(dac_chan), int'((k - 1) % NCH));
        end
    end

    // Monitor: runs in clock 4, just after the DAC latch
    always @(negedge clk) begin
        if (!rst && (ecount % 8 == 4) && sb.size() > 0) begin
            automatic exp_t e = sb.pop_front();
            if (e.chk) begin
                check(dac_sample == e.smp, {e.tag, " R5 sample"}, int'(dac_sample), int'(e.smp));
                check(dac_chan == e.ch, "R1 service order", int'(dac_chan), int'(e.ch));
            end
        end
    end

    // Host slot timing
    always @(negedge clk) begin
        if (!rst && chk_en)
            check(host_ready == (ecount % 8 == 4), "R3 ready slot",
                  int'(host_ready), int'(ecount % 8 == 4));
    end

    task automatic host_write(input logic tgt, input logic [WA_W-1:0] addr, input logic [ACC_W-1:0] data);
        @(negedge clk);
        host_valid = 1'b1;
        host_tgt   = tgt;
        host_addr  = addr;
        host_data  = data;
        while (!host_ready) @(negedge clk);
        if (tgt) m_wave[addr] = data[SMP_W-1:0];
        else     m_freq[addr[CH_W-1:0]] = data;
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic run_cycles(input int n);
        repeat (n * 8) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_acc[i]  = '0;
            m_freq[i] = '0;
        end
        for (int a = 0; a < WDEP; a++) m_wave[a] = '0;

        repeat (4) @(negedge clk);
        // R7: state while in reset
        check(dac_sample == 0, "R7 sample in reset", int'(dac_sample), 0);
        check(dac_chan == 0, "R7 tag in reset", int'(dac_chan), 0);
        check(host_ready == 0, "R7 ready in reset", int'(host_ready), 0);
        rst = 1'b0;
        @(negedge clk); @(negedge clk);
        check(dac_sample == 0, "R7 sample before first latch", int'(dac_sample), 0);
        check(dac_chan == 0, "R7 tag before first latch", int'(dac_chan), 0);

        // Preload the waveform table (R8 wave target)
        for (int a = 0; a < WDEP; a++) host_write(1'b1, WA_W'(a), ACC_W'(wave_fn(a)));

        // R7: zero frequency words and cleared accumulators
        scen = "R7";
        chk_en = 1;
        run_cycles(40);

        // R2: whole-step frequency words, varied rates and wraps
        scen = "R2";
        for (int c = 0; c < NCH; c++) host_write(1'b0, WA_W'(c), ACC_W'(16'h0400 * (c + 1)));
        run_cycles(300);

        // R2: fractional bits carrying into the address bits
        for (int c = 0; c < NCH; c++) host_write(1'b0, WA_W'(c), ACC_W'(16'h0123 * (c + 3)));
        run_cycles(300);

        // R4: words changed mid-run, one stepping backwards
        scen = "R4";
        host_write(1'b0, 10'd5, 16'hFC00);
        host_write(1'b0, 10'd0, 16'h0000);
        run_cycles(60);
        host_write(1'b0, 10'd0, 16'h0400);
        host_write(1'b0, 10'd9, 16'hFFFF);
        run_cycles(80);

        // R8: table overwrite and upper address bits ignored for frequency
        scen = "R8";
        for (int a = 0; a < 64; a++) host_write(1'b1, WA_W'(a), ACC_W'(~wave_fn(a)));
        host_write(1'b0, 10'h3C5, 16'h0800);
        host_write(1'b0, 10'h2A3, 16'h1C00);
        run_cycles(120);

        chk_en = 0;
        run_cycles(2);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule